// File: doc/BRIEF.md
# Programmable Serial Clock Generator

This block derives the serial clock of a serial peripheral master from the functional clock. An 8-bit divide code sets the half period of the serial clock to (code+1) functional cycles, which gives a serial frequency of f/(2*(code+1)) for codes 0 through 254. The code 255 (all ones) is a bypass: the serial clock then runs at the full functional rate.

The phase sequencer raises `run_i` for the length of a transaction. While `run_i` is low the serial clock rests at its idle level and the divide code, polarity and phase are captured into shadow registers. While `run_i` is high those shadow values are frozen and the block toggles the serial clock. On every serial edge it raises exactly one of two single-cycle strobes, launch or capture, chosen from the phase setting and from whether the edge is the leading or the trailing edge of a serial period. The sequencer uses these strobes to shift data out and sample data in. Computing the divide code from a target frequency is left to host software.

Control pins are plain level signals. There is no data stream through the block, so it has no valid/ready handshake.

Top module: `spi_sclk_gen`

## Requirements
- R1: After reset, and in every cycle after a rising clock edge that sampled `run_i` low, `sclk_o` equals the polarity captured at that edge (0 straight after reset) and `launch_o` and `capture_o` are both 0.
- R2: For a divide code D in 0..254, `sclk_o` changes level only at rising functional edges, once every D+1 cycles. This gives a serial period of 2*(D+1) functional cycles.
- R3: Let E0 be the first rising edge that samples `run_i` high. The first serial edge happens at rising edge E(D+1), and `sclk_o` holds the idle level until then.
- R4: With code 255 (bypass), from the cycle after E0 `sclk_o` equals the polarity in the high half of each functional cycle and its inverse in the low half. In each of those cycles one strobe is high.
- R5: Serial edges alternate between leading (the 1st, 3rd, ... edge after E0) and trailing. With phase 0, a leading edge raises `capture_o` and a trailing edge raises `launch_o`.
- R6: With phase 1, a leading edge raises `launch_o` and a trailing edge raises `capture_o`.
- R7: With polarity 1, the idle level is 1 and every serial level is the inverse of the level that polarity 0 would give.
- R8: A strobe is high for exactly the one cycle that starts at the rising edge where its serial edge occurs. After `run_i` has been low for one edge, a restart again places the first edge D+1 cycles after the new E0.
- R9: Changes to the divide code, polarity or phase while `run_i` is high have no effect until `run_i` has been sampled low.
- R10: `launch_o` and `capture_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Clock enable from the phase sequencer, high for a transaction |
| div_i | input | 8 | Divide code; 255 selects bypass |
| pol_i | input | 1 | Serial clock idle level |
| pha_i | input | 1 | Phase: 0 captures on leading edges, 1 launches on leading edges |
| sclk_o | output | 1 | Serial clock |
| launch_o | output | 1 | Single-cycle strobe marking a launch edge |
| capture_o | output | 1 | Single-cycle strobe marking a capture edge |

## Verification
The hardest case to reach is a configuration change in the middle of a running transaction. The frozen shadow must keep the old half period and edge roles, and the new settings must then appear only after an idle edge. To reach it, the stimulus starts a run with one divide code, waits until several edges have passed, and then drives a different code, polarity and phase while `run_i` stays high. It keeps checking the old pattern, drops `run_i` for one edge and restarts. A second hard case is the bypass clock. Its low half is seen only between functional edges, so the stimulus samples it a second time after each falling functional edge.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE    = 2'd0,
    EDGE_LAUNCH  = 2'd1,
    EDGE_CAPTURE = 2'd2
  } edge_kind_e;
endpackage

// File: rtl/sclk_cfg_hold.sv
module sclk_cfg_hold #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] div_in_i,
  input  logic         pol_in_i,
  input  logic         pha_in_i,
  output logic [W-1:0] div_o,
  output logic         pol_o,
  output logic         pha_o,
  output logic         bypass_o
);
  localparam logic [W-1:0] BypassCode = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o <= '0;
      pol_o <= 1'b0;
      pha_o <= 1'b0;
    end else if (!run_i) begin
      div_o <= div_in_i;
      pol_o <= pol_in_i;
      pha_o <= pha_in_i;
    end
  end

  assign bypass_o = (div_o == BypassCode);

  // R9: the shadow is frozen while a run continues
  p_cfg_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && run_i) |-> ($stable(div_o) && $stable(pol_o) && $stable(pha_o)));
endmodule

// File: rtl/sclk_div_count.sv
module sclk_div_count #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ticking_i,
  input  logic [W-1:0] div_i,
  input  logic         bypass_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic         at_end;

  assign at_end = (cnt_q == div_i);
  assign tick_o = ticking_i && (bypass_i || at_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!ticking_i || bypass_i || at_end) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2: the counter never runs past the divide code
  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ticking_i |-> (cnt_q <= div_i));
endmodule

// File: rtl/sclk_edge_seq.sv
module sclk_edge_seq
  import spi_sclk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic ticking_i,
  input  logic tick_i,
  input  logic pol_i,
  input  logic pha_i,
  input  logic bypass_i,
  output logic sclk_o,
  output logic launch_o,
  output logic capture_o
);
  logic       tog_q;
  logic       lead_q;
  logic       gate_q;
  edge_kind_e kind_q;
  edge_kind_e kind_nx;

  assign kind_nx = (lead_q ^ pha_i) ? EDGE_CAPTURE : EDGE_LAUNCH;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q  <= 1'b0;
      lead_q <= 1'b1;
      gate_q <= 1'b0;
      kind_q <= EDGE_NONE;
    end else if (!run_i) begin
      tog_q  <= 1'b0;
      lead_q <= 1'b1;
      gate_q <= 1'b0;
      kind_q <= EDGE_NONE;
    end else begin
      gate_q <= ticking_i && bypass_i;
      if (tick_i) begin
        tog_q  <= ~tog_q;
        lead_q <= ~lead_q;
        kind_q <= kind_nx;
      end else begin
        kind_q <= EDGE_NONE;
      end
    end
  end

  assign sclk_o    = pol_i ^ (gate_q ? ~clk_i : tog_q);
  assign launch_o  = (kind_q == EDGE_LAUNCH);
  assign capture_o = (kind_q == EDGE_CAPTURE);

  // R1: an idle edge leaves the clock at rest and silences the strobes
  p_idle_rest_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!run_i) |-> (sclk_o == pol_i && !launch_o && !capture_o));
  // R10: at most one strobe per cycle
  p_one_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({launch_o, capture_o}));
  // R2: in divided mode each strobe comes with a change of level
  p_strobe_level_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((launch_o || capture_o) && !bypass_i) |-> (tog_q != $past(tog_q)));
  // R5: strobes alternate between leading and trailing edges
  p_lead_alt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_o || capture_o) |-> (lead_q != $past(lead_q)));
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] div_i,
  input  logic         pol_i,
  input  logic         pha_i,
  output logic         sclk_o,
  output logic         launch_o,
  output logic         capture_o
);
  logic [W-1:0] div_q;
  logic         pol_q;
  logic         pha_q;
  logic         bypass_q;
  logic         active_q;
  logic         ticking;
  logic         tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else         active_q <= run_i;
  end

  assign ticking = run_i && active_q;

  sclk_cfg_hold #(.W(W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .div_in_i (div_i),
    .pol_in_i (pol_i),
    .pha_in_i (pha_i),
    .div_o    (div_q),
    .pol_o    (pol_q),
    .pha_o    (pha_q),
    .bypass_o (bypass_q)
  );

  sclk_div_count #(.W(W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ticking_i (ticking),
    .div_i     (div_q),
    .bypass_i  (bypass_q),
    .tick_o    (tick)
  );

  sclk_edge_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .ticking_i (ticking),
    .tick_i    (tick),
    .pol_i     (pol_q),
    .pha_i     (pha_q),
    .bypass_i  (bypass_q),
    .sclk_o    (sclk_o),
    .launch_o  (launch_o),
    .capture_o (capture_o)
  );

  // R3: no serial edge on the edge that first samples the run request
  p_no_early_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !active_q) |=> (!launch_o && !capture_o));
endmodule

// File: tb/test_spi_sclk_gen.sv
module test_spi_sclk_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       run_i = 1'b0;
  logic [7:0] div_i = 8'd0;
  logic       pol_i = 1'b0;
  logic       pha_i = 1'b0;
  logic       sclk_o, launch_o, capture_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk_i = ~clk_i;

  spi_sclk_gen i_spi_sclk_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .div_i(div_i),
    .pol_i(pol_i), .pha_i(pha_i), .sclk_o(sclk_o),
    .launch_o(launch_o), .capture_o(capture_o)
  );

  // div[19:12] pol[11] pha[10] cycles[9:0]
  localparam int NV = 9;
  localparam logic [19:0] VEC [NV] = '{
    {8'd0,   1'b0, 1'b0, 10'd20},
    {8'd1,   1'b0, 1'b1, 10'd24},
    {8'd3,   1'b1, 1'b0, 10'd40},
    {8'd4,   1'b1, 1'b1, 10'd40},
    {8'd2,   1'b1, 1'b1, 10'd30},
    {8'd7,   1'b0, 1'b0, 10'd50},
    {8'd254, 1'b0, 1'b1, 10'd600},
    {8'd255, 1'b0, 1'b0, 10'd12},
    {8'd255, 1'b1, 1'b1, 10'd12}
  };

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {sclk,launch,capture} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // expected {sclk, launch, capture} in cycle k after E0, sampled with clk high
  function automatic logic [2:0] model(input int d, input logic p, input logic h, input int k);
    int  half;
    int  n;
    logic stb, lead;
    half = (d == 255) ? 1 : d + 1;
    n    = k / half;
    stb  = (k >= 1) && (k % half == 0);
    lead = n[0];
    if (d == 255) return {p, stb && (lead == h), stb && (lead != h)};
    return {p ^ n[0], stb && (lead == h), stb && (lead != h)};
  endfunction

  function automatic string tag(input int d, input logic p, input logic h);
    if (d == 255) return "R4";
    if (p)        return "R7";
    if (h)        return "R6";
    return "R5";
  endfunction

  task automatic run_cycles(input int d, input logic p, input logic h, input int n, input string req);
    for (int k = 0; k <= n; k++) begin
      @(posedge clk_i); #2;
      chk(k <= d + 1 ? "R3" : req, {sclk_o, launch_o, capture_o}, model(d, p, h, k));
      if (d == 255) begin
        #5;
        chk("R4", {sclk_o, 2'b00}, {(k >= 1) ? ~p : p, 2'b00});
      end
    end
  endtask

  task automatic idle_with(input int d, input logic p, input logic h);
    @(negedge clk_i);
    run_i = 1'b0; div_i = d[7:0]; pol_i = p; pha_i = h;
    @(posedge clk_i); #2;
    chk("R1", {sclk_o, launch_o, capture_o}, {p, 2'b00});
  endtask

  initial begin
    #4;
    chk("R1", {sclk_o, launch_o, capture_o}, 3'b000);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // table walk: R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      int d;
      logic p, h;
      d = int'(VEC[v][19:12]); p = VEC[v][11]; h = VEC[v][10];
      idle_with(d, p, h);
      @(negedge clk_i) run_i = 1'b1;
      run_cycles(d, p, h, int'(VEC[v][9:0]), d == 255 ? "R4" : (d < 2 ? "R2" : tag(d, p, h)));
      @(negedge clk_i) run_i = 1'b0;
      @(posedge clk_i); #2;
      chk("R8", {sclk_o, launch_o, capture_o}, {p, 2'b00});
    end

    // R9: mid-run change is ignored; R8: restart after one idle edge
    idle_with(2, 1'b0, 1'b0);
    @(negedge clk_i) run_i = 1'b1;
    for (int k = 0; k <= 14; k++) begin
      @(posedge clk_i); #2;
      chk("R9", {sclk_o, launch_o, capture_o}, model(2, 1'b0, 1'b0, k));
      if (k == 4) begin
        @(negedge clk_i);
        div_i = 8'd0; pol_i = 1'b1; pha_i = 1'b1;
      end
    end
    @(negedge clk_i) run_i = 1'b0;
    @(posedge clk_i); #2;
    chk("R9", {sclk_o, launch_o, capture_o}, 3'b100);
    @(negedge clk_i) run_i = 1'b1;
    run_cycles(0, 1'b1, 1'b1, 6, "R8");

    // R10: strobes exclusive over a bypass burst and a fast divided burst
    idle_with(255, 1'b0, 1'b1);
    @(negedge clk_i) run_i = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk_i); #2;
      chk("R10", {1'b0, launch_o & capture_o, 1'b0}, 3'b000);
    end
    @(negedge clk_i) run_i = 1'b0;
    @(posedge clk_i); #2;
    chk("R1", {sclk_o, launch_o, capture_o}, 3'b000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule